// File: doc/BRIEF.md
# Fused Multiply-Accumulate Compressor Tree

This combinational block returns a RES_W-bit value, taken modulo 2^RES_W. The value combines NUM_PROD unsigned products A_k*B_k and NUM_ADD plain addends D_m. A compile-time mask sets each term to be added or subtracted. No product is resolved on its own. Each product becomes a matrix of radix-2 partial-product rows, one row per bit of its A factor. Those rows, the addends and a single correction word all enter one carry-save compressor tree.

The tree works in readiness levels. At each level the operands that are ready are grouped into 4:2 compressors, or only into 3:2 compressors if the parameter selects that. A 4:2 compressor adds two levels of readiness depth and a 3:2 compressor adds one. One carry-propagate adder resolves the two vectors that leave the tree. That adder is a plain ripple form below a width threshold and a parallel-prefix form at or above it.

A subtracted term is inverted, row by row for products. Each inverted row adds one unit to the correction word. Elaboration stops if any factor is declared signed, or if a configuration with no products has fewer than three addends.

Top module: `fmac_tree`

## Requirements
- R1: y_o equals the sum of s_k*A_k*B_k over all products plus s_m*D_m over all addends, modulo 2^RES_W, where s is +1 for an added term and -1 for a subtracted one.
- R2: SUB_MASK bit k (0 to NUM_PROD-1) marks product k as subtracted, and bit NUM_PROD+m marks addend m as subtracted. A set bit gives the two's-complement negation of that term modulo 2^RES_W.
- R3: Results wrap modulo 2^RES_W with no saturation, including all-ones factors and all-ones addends.
- R4: All-zero inputs give y_o = 0 for any SUB_MASK. The correction word exactly cancels the inverted rows.
- R5: A configuration with one product and no addends still goes through the tree and returns A*B modulo 2^RES_W.
- R6: The result does not depend on the reduction mode. RED_MODE = RED_4_2 and RED_MODE = RED_3_2 give the same value.
- R7: The two vectors that leave the compressor tree add, modulo 2^RES_W, to the sum of all rows that enter it.
- R8: Partial-product row i of a product is B shifted left by i, truncated to RES_W bits, and gated by A bit i. A zero A factor contributes nothing. A one-hot A factor with bit i set contributes B<<i.
- R9: The final adder gives the same sum in its ripple form (RES_W < PREFIX_MIN_W) and in its parallel-prefix form (RES_W >= PREFIX_MIN_W).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | NUM_PROD*A_W | A factors; product k at bits [k*A_W +: A_W] |
| b_i | input | NUM_PROD*B_W | B factors; product k at bits [k*B_W +: B_W] |
| addend_i | input | NUM_ADD*RES_W | Plain addends; addend m at bits [m*RES_W +: RES_W] |
| y_o | output | RES_W | Accumulated result modulo 2^RES_W |

## Verification
Three instances share their stimulus and are checked against a modular reference sum. The first mixes added and subtracted terms and uses the prefix adder. The second subtracts every term and uses only 3:2 reduction. The third has one product, no addends, and the ripple adder. All-zero inputs show whether the correction word cancels the inverted rows exactly. All-ones factors and addends exercise the wrap. A one-hot A and a zero A expose faults in row shifting and row gating. Runs with only addends and with only products separate faults in the addend inversion from faults in the product-row inversion. Random patterns then stress the level scheduling of the tree.

// File: rtl/fmac_pkg.sv
package fmac_pkg;

  typedef enum logic {
    RED_3_2 = 1'b0,
    RED_4_2 = 1'b1
  } red_mode_e;

  function automatic int max_i(input int x, input int y);
    return (x > y) ? x : y;
  endfunction

  // one unit per inverted row: A_W rows per subtracted product, one per subtracted addend
  function automatic int corr_units(input int n_prod, input int n_add, input int a_w,
                                    input logic [63:0] mask);
    int c;
    c = 0;
    for (int k = 0; k < n_prod; k++) if (mask[6'(k)]) c += a_w;
    for (int m = 0; m < n_add; m++) if (mask[6'(n_prod + m)]) c += 1;
    return c;
  endfunction

endpackage

// File: rtl/fmac_pp_gen.sv
module fmac_pp_gen #(
  parameter int A_W   = 8,
  parameter int B_W   = 8,
  parameter int RES_W = 16
) (
  input  logic [A_W-1:0]            a_i,
  input  logic [B_W-1:0]            b_i,
  output logic [A_W-1:0][RES_W-1:0] rows_o
);

  localparam int EXT_W = RES_W + B_W + A_W;

  for (genvar i = 0; i < A_W; i++) begin : g_row
    logic [EXT_W-1:0] shifted;
    assign shifted   = EXT_W'(b_i) << i;
    assign rows_o[i] = shifted[RES_W-1:0] & {RES_W{a_i[i]}};
  end

endmodule

// File: rtl/fmac_csa_tree.sv
module fmac_csa_tree import fmac_pkg::*; #(
  parameter int        N_IN     = 8,
  parameter int        RES_W    = 16,
  parameter red_mode_e RED_MODE = RED_4_2
) (
  input  logic [N_IN-1:0][RES_W-1:0] rows_i,
  output logic [RES_W-1:0]           sum_o,
  output logic [RES_W-1:0]           cry_o
);

  localparam int NP   = N_IN + 4;
  localparam int IW   = $clog2(NP);
  localparam int LVLS = 2 * N_IN + 4;

  // {carry<<1, sum}
  function automatic logic [2*RES_W-1:0] csa3(input logic [RES_W-1:0] x, y, z);
    logic [RES_W-1:0] s, c;
    s = x ^ y ^ z;
    c = (x & y) | (x & z) | (y & z);
    c = c << 1;
    return {c, s};
  endfunction

  function automatic logic [2*RES_W-1:0] csa4(input logic [RES_W-1:0] x, y, z, w);
    logic [2*RES_W-1:0] h;
    h = csa3(x, y, z);
    return csa3(h[RES_W-1:0], w, h[2*RES_W-1:RES_W]);
  endfunction

  logic [RES_W-1:0]   cur [NP];
  logic [RES_W-1:0]   rdy [NP];
  logic [RES_W-1:0]   wt  [NP];
  logic [RES_W-1:0]   nx  [NP];
  int                 cdep[NP];
  int                 rdep[NP];
  int                 wdep[NP];
  int                 ndep[NP];
  int                 cnt, nr, nw, nn, pos, rem, dm;
  logic [2*RES_W-1:0] pr;

  always_comb begin
    for (int j = 0; j < NP; j++) begin
      cur[IW'(j)]  = '0;
      rdy[IW'(j)]  = '0;
      wt[IW'(j)]   = '0;
      nx[IW'(j)]   = '0;
      cdep[IW'(j)] = 0;
      rdep[IW'(j)] = 0;
      wdep[IW'(j)] = 0;
      ndep[IW'(j)] = 0;
    end
    for (int j = 0; j < N_IN; j++) cur[IW'(j)] = rows_i[j];
    cnt = N_IN;
    nr  = 0;
    nw  = 0;
    nn  = 0;
    pos = 0;
    rem = 0;
    dm  = 0;
    pr  = '0;
    for (int lv = 0; lv < LVLS; lv++) begin
      if (cnt > 2) begin
        nr = 0;
        nw = 0;
        for (int j = 0; j < NP; j++) begin
          if (j < cnt) begin
            if (cdep[IW'(j)] <= lv) begin
              rdy[IW'(nr)]  = cur[IW'(j)];
              rdep[IW'(nr)] = cdep[IW'(j)];
              nr++;
            end else begin
              wt[IW'(nw)]   = cur[IW'(j)];
              wdep[IW'(nw)] = cdep[IW'(j)];
              nw++;
            end
          end
        end
        if (nr >= 3) begin
          nn  = 0;
          pos = 0;
          for (int g = 0; g < NP; g++) begin
            rem = nr - pos;
            if (RED_MODE == RED_4_2 && rem >= 4) begin
              pr = csa4(rdy[IW'(pos)], rdy[IW'(pos+1)], rdy[IW'(pos+2)], rdy[IW'(pos+3)]);
              dm = max_i(max_i(rdep[IW'(pos)], rdep[IW'(pos+1)]),
                         max_i(rdep[IW'(pos+2)], rdep[IW'(pos+3)])) + 2;
              nx[IW'(nn)]     = pr[RES_W-1:0];
              nx[IW'(nn+1)]   = pr[2*RES_W-1:RES_W];
              ndep[IW'(nn)]   = dm;
              ndep[IW'(nn+1)] = dm;
              nn  += 2;
              pos += 4;
            end else if (rem >= 3) begin
              pr = csa3(rdy[IW'(pos)], rdy[IW'(pos+1)], rdy[IW'(pos+2)]);
              dm = max_i(max_i(rdep[IW'(pos)], rdep[IW'(pos+1)]), rdep[IW'(pos+2)]) + 1;
              nx[IW'(nn)]     = pr[RES_W-1:0];
              nx[IW'(nn+1)]   = pr[2*RES_W-1:RES_W];
              ndep[IW'(nn)]   = dm;
              ndep[IW'(nn+1)] = dm;
              nn  += 2;
              pos += 3;
            end else if (rem > 0) begin
              // residual operands wait for the next level untouched
              nx[IW'(nn)]   = rdy[IW'(pos)];
              ndep[IW'(nn)] = rdep[IW'(pos)];
              nn++;
              pos++;
            end
          end
          for (int j = 0; j < NP; j++) begin
            if (j < nw) begin
              nx[IW'(nn+j)]   = wt[IW'(j)];
              ndep[IW'(nn+j)] = wdep[IW'(j)];
            end
          end
          cnt = nn + nw;
          for (int j = 0; j < NP; j++) begin
            cur[IW'(j)]  = nx[IW'(j)];
            cdep[IW'(j)] = ndep[IW'(j)];
          end
        end
      end
    end
    sum_o = (cnt >= 1) ? cur[0] : '0;
    cry_o = (cnt >= 2) ? cur[1] : '0;
  end

endmodule

// File: rtl/fmac_cpa.sv
module fmac_cpa #(
  parameter int RES_W        = 16,
  parameter int PREFIX_MIN_W = 16
) (
  input  logic [RES_W-1:0] x_i,
  input  logic [RES_W-1:0] y_i,
  output logic [RES_W-1:0] sum_o
);

  if (RES_W < PREFIX_MIN_W || RES_W < 2) begin : g_ripple
    assign sum_o = x_i + y_i;
  end else begin : g_prefix
    localparam int LV = $clog2(RES_W);
    logic [LV:0][RES_W-1:0] gk;
    logic [LV:0][RES_W-1:0] pk;

    assign gk[0] = x_i & y_i;
    assign pk[0] = x_i ^ y_i;

    for (genvar l = 0; l < LV; l++) begin : g_lvl
      localparam int D = 1 << l;
      for (genvar i = 0; i < RES_W; i++) begin : g_bit
        if (i >= D) begin : g_comb
          assign gk[l+1][i] = gk[l][i] | (pk[l][i] & gk[l][i-D]);
          assign pk[l+1][i] = pk[l][i] & pk[l][i-D];
        end else begin : g_pass
          assign gk[l+1][i] = gk[l][i];
          assign pk[l+1][i] = pk[l][i];
        end
      end
    end

    assign sum_o[0] = pk[0][0];
    for (genvar i = 1; i < RES_W; i++) begin : g_sum
      assign sum_o[i] = pk[0][i] ^ gk[LV][i-1];
    end
  end

endmodule

// File: rtl/fmac_tree.sv
module fmac_tree import fmac_pkg::*; #(
  parameter int                          NUM_PROD     = 2,
  parameter int                          NUM_ADD      = 2,
  parameter int                          A_W          = 8,
  parameter int                          B_W          = 8,
  parameter int                          RES_W        = 16,
  parameter logic [NUM_PROD+NUM_ADD-1:0] SUB_MASK     = '0,
  parameter red_mode_e                   RED_MODE     = RED_4_2,
  parameter int                          PREFIX_MIN_W = 16,
  parameter bit                          A_SIGNED     = 1'b0,
  parameter bit                          B_SIGNED     = 1'b0,
  localparam int                         A_BITS       = max_i(1, NUM_PROD * A_W),
  localparam int                         B_BITS       = max_i(1, NUM_PROD * B_W),
  localparam int                         D_BITS       = max_i(1, NUM_ADD * RES_W)
) (
  input  logic [A_BITS-1:0] a_i,
  input  logic [B_BITS-1:0] b_i,
  input  logic [D_BITS-1:0] addend_i,
  output logic [RES_W-1:0]  y_o
);

  localparam int CORR    = corr_units(NUM_PROD, NUM_ADD, A_W, 64'(SUB_MASK));
  localparam int N_PP    = NUM_PROD * A_W;
  localparam int PP_BITS = max_i(1, N_PP);
  localparam int N_ROW   = N_PP + NUM_ADD + ((CORR > 0) ? 1 : 0);

  if (A_SIGNED || B_SIGNED) begin : g_bad_sign
    $error("fmac_tree: only unsigned factors are supported");
  end
  if (NUM_PROD == 0 && NUM_ADD < 3) begin : g_bad_cfg
    $error("fmac_tree: additive-only use needs at least three addends");
  end

  logic [PP_BITS-1:0][RES_W-1:0] pp_raw;
  logic [N_ROW-1:0][RES_W-1:0]   pool;
  logic [RES_W-1:0]              tree_sum;
  logic [RES_W-1:0]              tree_cry;

  if (NUM_PROD == 0) begin : g_no_pp
    assign pp_raw = '0;
  end

  for (genvar k = 0; k < NUM_PROD; k++) begin : g_prod
    fmac_pp_gen #(
      .A_W  (A_W),
      .B_W  (B_W),
      .RES_W(RES_W)
    ) u_pp (
      .a_i   (a_i[k*A_W +: A_W]),
      .b_i   (b_i[k*B_W +: B_W]),
      .rows_o(pp_raw[k*A_W +: A_W])
    );
    for (genvar i = 0; i < A_W; i++) begin : g_row
      assign pool[k*A_W+i] = SUB_MASK[k] ? ~pp_raw[k*A_W+i] : pp_raw[k*A_W+i];
    end
  end

  for (genvar m = 0; m < NUM_ADD; m++) begin : g_add
    assign pool[N_PP+m] = SUB_MASK[NUM_PROD+m] ? ~addend_i[m*RES_W +: RES_W]
                                               : addend_i[m*RES_W +: RES_W];
  end

  if (CORR > 0) begin : g_corr
    assign pool[N_ROW-1] = RES_W'(CORR);
  end

  fmac_csa_tree #(
    .N_IN    (N_ROW),
    .RES_W   (RES_W),
    .RED_MODE(RED_MODE)
  ) u_tree (
    .rows_i(pool),
    .sum_o (tree_sum),
    .cry_o (tree_cry)
  );

  fmac_cpa #(
    .RES_W       (RES_W),
    .PREFIX_MIN_W(PREFIX_MIN_W)
  ) u_cpa (
    .x_i  (tree_sum),
    .y_i  (tree_cry),
    .sum_o(y_o)
  );

endmodule

// File: rtl/fmac_tree_chk.sv
module fmac_tree_chk import fmac_pkg::*; #(
  parameter int                          NUM_PROD = 2,
  parameter int                          NUM_ADD  = 2,
  parameter int                          A_W      = 8,
  parameter int                          B_W      = 8,
  parameter int                          RES_W    = 16,
  parameter logic [NUM_PROD+NUM_ADD-1:0] SUB_MASK = '0,
  localparam int                         A_BITS   = max_i(1, NUM_PROD * A_W),
  localparam int                         B_BITS   = max_i(1, NUM_PROD * B_W),
  localparam int                         D_BITS   = max_i(1, NUM_ADD * RES_W),
  localparam int                         CORR     = corr_units(NUM_PROD, NUM_ADD, A_W, 64'(SUB_MASK)),
  localparam int                         N_PP     = NUM_PROD * A_W,
  localparam int                         PP_BITS  = max_i(1, N_PP),
  localparam int                         N_ROW    = N_PP + NUM_ADD + ((CORR > 0) ? 1 : 0)
) (
  input logic [A_BITS-1:0]               a_i,
  input logic [B_BITS-1:0]               b_i,
  input logic [D_BITS-1:0]               addend_i,
  input logic [RES_W-1:0]                y_o,
  input logic [PP_BITS-1:0][RES_W-1:0]   pp_raw,
  input logic [N_ROW-1:0][RES_W-1:0]     pool,
  input logic [RES_W-1:0]                tree_sum,
  input logic [RES_W-1:0]                tree_cry
);

  logic [RES_W-1:0] ref_y, pool_sum, prod, row_sum;
  logic             all_zero;

  always_comb begin
    ref_y = '0;
    for (int k = 0; k < NUM_PROD; k++) begin
      prod = RES_W'(a_i[k*A_W +: A_W]) * RES_W'(b_i[k*B_W +: B_W]);
      ref_y = SUB_MASK[k] ? ref_y - prod : ref_y + prod;
    end
    for (int m = 0; m < NUM_ADD; m++) begin
      ref_y = SUB_MASK[NUM_PROD+m] ? ref_y - addend_i[m*RES_W +: RES_W]
                                   : ref_y + addend_i[m*RES_W +: RES_W];
    end
    pool_sum = '0;
    for (int r = 0; r < N_ROW; r++) pool_sum = pool_sum + pool[r];
    all_zero = (a_i == '0) && (b_i == '0) && (NUM_ADD == 0 || addend_i == '0);
    prod     = '0;
    row_sum  = '0;

    AST_RESULT_MATCH: assert (y_o == ref_y);                                   // R1
    AST_TREE_CONSERVE: assert (RES_W'(tree_sum + tree_cry) == pool_sum);        // R7
    if (all_zero) begin
      AST_ZERO_IN: assert (y_o == '0);                                         // R4
    end
    for (int k = 0; k < NUM_PROD; k++) begin
      row_sum = '0;
      for (int i = 0; i < A_W; i++) begin
        row_sum = row_sum + pp_raw[k*A_W+i];
        if (!a_i[k*A_W+i]) begin
          AST_ROW_GATED: assert (pp_raw[k*A_W+i] == '0);                       // R8
        end
      end
      prod = RES_W'(a_i[k*A_W +: A_W]) * RES_W'(b_i[k*B_W +: B_W]);
      AST_ROWS_FORM_PRODUCT: assert (row_sum == prod);                         // R8
    end
  end

endmodule

bind fmac_tree fmac_tree_chk #(
  .NUM_PROD(NUM_PROD),
  .NUM_ADD (NUM_ADD),
  .A_W     (A_W),
  .B_W     (B_W),
  .RES_W   (RES_W),
  .SUB_MASK(SUB_MASK)
) u_chk (
  .a_i     (a_i),
  .b_i     (b_i),
  .addend_i(addend_i),
  .y_o     (y_o),
  .pp_raw  (pp_raw),
  .pool    (pool),
  .tree_sum(tree_sum),
  .tree_cry(tree_cry)
);

// File: tb/fmac_tree_tb.sv
module fmac_tree_tb;
  import fmac_pkg::*;

  localparam logic [3:0] MASK0 = 4'b0110;  // product 1 and addend 0 subtracted
  localparam logic [3:0] MASK1 = 4'b1111;  // every term subtracted

  logic clk = 1'b0;
  logic rst_ni;
  always #5 clk = ~clk;

  logic [15:0] a_s, b_s;
  logic [31:0] d_s;
  logic [5:0]  a1_s;
  logic [4:0]  b1_s;
  logic [15:0] y0, y1;
  logic [8:0]  y2;

  fmac_tree #(.NUM_PROD(2), .NUM_ADD(2), .A_W(8), .B_W(8), .RES_W(16),
              .SUB_MASK(MASK0), .RED_MODE(RED_4_2), .PREFIX_MIN_W(16))
  u_dut (.a_i(a_s), .b_i(b_s), .addend_i(d_s), .y_o(y0));

  fmac_tree #(.NUM_PROD(2), .NUM_ADD(2), .A_W(8), .B_W(8), .RES_W(16),
              .SUB_MASK(MASK1), .RED_MODE(RED_3_2), .PREFIX_MIN_W(16))
  u_dut_fa (.a_i(a_s), .b_i(b_s), .addend_i(d_s), .y_o(y1));

  fmac_tree #(.NUM_PROD(1), .NUM_ADD(0), .A_W(6), .B_W(5), .RES_W(9),
              .SUB_MASK(1'b0), .RED_MODE(RED_4_2), .PREFIX_MIN_W(16))
  u_dut_one (.a_i(a1_s), .b_i(b1_s), .addend_i(1'b0), .y_o(y2));

  typedef struct {
    logic [15:0] e0;
    logic [15:0] e1;
    logic [8:0]  e2;
    string       lbl;
  } item_t;

  item_t q[$];
  int    n_chk = 0;
  int    n_err = 0;

  function automatic logic [15:0] ref2(input logic [15:0] a, input logic [15:0] b,
                                       input logic [31:0] d, input logic [3:0] m);
    logic [31:0] acc, t;
    acc = '0;
    for (int k = 0; k < 2; k++) begin
      t   = 32'(a[k*8 +: 8]) * 32'(b[k*8 +: 8]);
      acc = m[k] ? acc - t : acc + t;
    end
    for (int j = 0; j < 2; j++) begin
      t   = 32'(d[j*16 +: 16]);
      acc = m[2+j] ? acc - t : acc + t;
    end
    return acc[15:0];
  endfunction

  function automatic logic [8:0] ref1(input logic [5:0] a, input logic [4:0] b);
    logic [31:0] t;
    t = 32'(a) * 32'(b);
    return t[8:0];
  endfunction

  task automatic drive(input logic [15:0] a, input logic [15:0] b, input logic [31:0] d,
                       input logic [5:0] a1, input logic [4:0] b1, input string lbl);
    @(posedge clk);
    a_s  = a;
    b_s  = b;
    d_s  = d;
    a1_s = a1;
    b1_s = b1;
    q.push_back('{ref2(a, b, d, MASK0), ref2(a, b, d, MASK1), ref1(a1, b1), lbl});
  endtask

  task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string who,
                     input string lbl);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s [%s] got %h exp %h", who, lbl, got, exp);
    end
  endtask

  // monitor: results of the item driven at the previous posedge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      chk(y0, it.e0, "R1 R2 R9 u_dut", it.lbl);
      chk(y1, it.e1, "R2 R6 u_dut_fa", it.lbl);
      chk(16'(y2), 16'(it.e2), "R5 R9 u_dut_one", it.lbl);
    end
  end

  initial begin
    rst_ni = 1'b0;
    a_s = '0; b_s = '0; d_s = '0; a1_s = '0; b1_s = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    drive(16'h0000, 16'h0000, 32'h0000_0000, 6'h00, 5'h00, "R4 zero inputs after reset");
    drive(16'hffff, 16'hffff, 32'hffff_ffff, 6'h3f, 5'h1f, "R3 all-ones wrap");
    drive(16'h0208, 16'h7fa5, 32'h0000_0000, 6'h10, 5'h13, "R8 one-hot A");
    drive(16'h0000, 16'hffff, 32'h0000_0000, 6'h00, 5'h1f, "R8 zero A gates rows");
    drive(16'h0000, 16'h0000, 32'hffff_0001, 6'h01, 5'h01, "R2 addends only");
    drive(16'hc3ff, 16'hffe7, 32'h0000_0000, 6'h2a, 5'h15, "R2 products only");
    drive(16'h00ff, 16'hff00, 32'h8000_7fff, 6'h3f, 5'h01, "R3 half-ones mix");
    for (int n = 0; n < 40; n++) begin
      drive(16'($urandom()), 16'($urandom()), $urandom(), 6'($urandom()), 5'($urandom()),
            "R1 R7 random");
    end
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired, R1 results incomplete");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule